// File: doc/BRIEF.md
# USB IN Endpoint NAK Controller

This block decides how one IN endpoint of a full-speed USB device answers each IN token. It keeps a small queue of packet lengths that stand for packets already written into the transmit FIFO. It tracks the free byte count of that FIFO, and it tells software whether a packet of a given length may be committed. On a token it answers with a data packet, a NAK handshake or a zero-length data packet, depending on the endpoint type, the queue contents and the NAK state.

Software stops the endpoint with a one-cycle set-NAK pulse and restarts it with a one-cycle clear-NAK pulse. NAK mode only takes hold at a transaction boundary. A data packet that is waiting for its handshake finishes first, and so does a packet started while the request is pending. When NAK mode takes hold, a sticky status bit rises. That bit drives a maskable interrupt line, and clear-NAK drops it again. Non-isochronous data leaves the queue only on a host ACK. Isochronous data leaves the queue as soon as it is sent.

Top module: `in_ep_nak_ctrl`

## Requirements
- R1: After reset the endpoint is out of NAK mode, `nak_eff` and `nak_irq` are 0, `resp` is 0, `free_bytes` equals FIFO_BYTES (64) and `txfe_irq` is 1.
- R2: A commit of a non-zero length is accepted only when the length does not exceed `free_bytes` (and MAX_PKT) and a slot is free. `room_ok` shows this for the length on `pkt_len`. An accepted commit lowers `free_bytes` by the length on the next cycle. A refused commit leaves it unchanged.
- R3: A zero-length commit is accepted whatever `free_bytes` is, while a slot is free, and it consumes no bytes.
- R4: Out of NAK mode, a token with a packet queued gives `resp`=1 (data) one cycle later, with `tx_len` equal to the oldest queued length. With the queue empty, a token gives `resp`=2 (NAK) when `ep_iso`=0 and `resp`=3 (zero-length) when `ep_iso`=1.
- R5: On a non-isochronous endpoint, a sent packet is removed and its bytes are freed only on `host_ack`. On `host_timeout` it is kept and sent again on the next token.
- R6: On an isochronous endpoint, a sent packet is removed and its bytes are freed in the same cycle that `resp`=1 appears.
- R7: In NAK mode, a token on a non-isochronous endpoint gets `resp`=2, even with a packet queued, and the queue is left unchanged.
- R8: In NAK mode, a token on an isochronous endpoint gets `resp`=3, and the queue is left unchanged.
- R9: With no transaction in flight, `nak_mode` and `nak_eff` rise two clock edges after set-NAK is sampled. A data transaction in flight, or one started by a token in the cycle after set-NAK, completes first. NAK takes hold on the edge after its handshake.
- R10: Clear-NAK leaves NAK mode and clears `nak_eff` on the next edge. The kept packet is then sent on the first token.
- R11: When set-NAK and clear-NAK arrive in the same cycle, clear-NAK wins: the next state is out of NAK mode with `nak_eff`=0.
- R12: `nak_irq` is `nak_eff` gated by `nak_irq_mask`=0. With the mask at 1, `nak_eff` still sets, but `nak_irq` stays 0.
- R13: `txfe_irq` is 1 exactly when no packet is queued, and `free_bytes` reports the free FIFO bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_iso | input | 1 | Endpoint is isochronous |
| set_nak | input | 1 | Set-NAK command pulse |
| clr_nak | input | 1 | Clear-NAK command pulse |
| nak_irq_mask | input | 1 | 1 masks the NAK-effective interrupt |
| in_token | input | 1 | IN token received, one cycle |
| host_ack | input | 1 | Host ACK for the data in flight |
| host_timeout | input | 1 | No handshake for the data in flight |
| pkt_commit | input | 1 | Commit a packet of length pkt_len |
| pkt_len | input | 7 | Length in bytes of the packet to commit |
| room_ok | output | 1 | A commit of pkt_len would be accepted |
| resp | output | 2 | 0 none, 1 data, 2 NAK, 3 zero-length data |
| tx_len | output | 7 | Length of the data packet sent with resp=1 |
| nak_mode | output | 1 | NAK mode in effect |
| nak_eff | output | 1 | Sticky NAK-effective status |
| nak_irq | output | 1 | NAK-effective interrupt line |
| txfe_irq | output | 1 | Transmit FIFO empty interrupt |
| free_bytes | output | 7 | Free bytes in the transmit FIFO |

## Verification
A wrong NAK state shows on the first token after the fault. A data response where a NAK or a zero-length packet was due, or the reverse, exposes it within one cycle of that token. It also shows on `nak_eff` two edges after a set-NAK pulse. A slip in the queue or the byte accounting shows at once on `free_bytes` and `room_ok`. A bad read pointer shows as a wrong `tx_len` on the next data response. The directed tests also hold a packet across timeouts and NAK periods, so a packet that is lost or popped twice appears as a wrong length or a wrong free count within a few cycles.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;

  typedef enum logic [1:0] {
    RESP_NONE = 2'd0,
    RESP_DATA = 2'd1,
    RESP_NAK  = 2'd2,
    RESP_ZLP  = 2'd3
  } resp_e;

  typedef enum logic [1:0] {
    NK_RUN  = 2'd0,
    NK_PEND = 2'd1,
    NK_HELD = 2'd2
  } nak_st_e;

endpackage

// File: rtl/in_ep_pktq.sv
module in_ep_pktq #(
  parameter int FIFO_BYTES = 64,
  parameter int SLOTS      = 4,
  parameter int LEN_W      = 7,
  parameter int FREE_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [LEN_W-1:0]  commit_len,
  input  logic              pop,
  output logic [LEN_W-1:0]  head_len,
  output logic              empty,
  output logic              room_ok,
  output logic [FREE_W-1:0] free_bytes
);

  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [LEN_W-1:0]  slot_q [SLOTS];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FREE_W-1:0] free_q;
  logic              full;
  logic              commit_acc;
  logic              pop_ok;

  // Space rule: an empty packet never needs room; others need all of it.
  function automatic logic fits_len(input logic [LEN_W-1:0] len,
                                    input logic [FREE_W-1:0] free);
    return (len == '0) || (32'(len) <= 32'(free));
  endfunction

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (32'(p) == SLOTS - 1) return '0;
    return p + 1'b1;
  endfunction

  function automatic logic [FREE_W-1:0] free_next(input logic [FREE_W-1:0] f,
                                                  input logic add_en,
                                                  input logic [LEN_W-1:0] add,
                                                  input logic sub_en,
                                                  input logic [LEN_W-1:0] sub);
    int r;
    r = 32'(f);
    if (add_en) r = r + 32'(add);
    if (sub_en) r = r - 32'(sub);
    return FREE_W'(r);
  endfunction

  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == CNT_W'(SLOTS));
  assign room_ok    = !full && fits_len(commit_len, free_q);
  assign commit_acc = commit && room_ok;
  assign pop_ok     = pop && !empty;
  assign head_len   = slot_q[rd_ptr_q];
  assign free_bytes = free_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else if (commit_acc) begin
      slot_q[wr_ptr_q] <= commit_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      free_q   <= FREE_W'(FIFO_BYTES);
    end else begin
      if (commit_acc) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)     rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({commit_acc, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      free_q <= free_next(free_q, pop_ok, head_len, commit_acc, commit_len);
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_q) <= FIFO_BYTES);

  assert_commit_debit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_acc && !pop_ok) |=> 32'(free_q) == 32'($past(free_q)) - 32'($past(commit_len)));

  assert_empty_all_free_R13: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> 32'(free_q) == FIFO_BYTES);

endmodule

// File: rtl/in_ep_nak_fsm.sv
module in_ep_nak_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic set_nak,
  input  logic clr_nak,
  input  logic busy,
  input  logic in_token,
  output logic nak_mode,
  output logic nak_eff
);
  import in_ep_pkg::*;

  nak_st_e state_q, state_d;
  logic    nak_eff_q;
  logic    boundary;

  // A boundary is a cycle with no handshake pending and no token arriving.
  assign boundary = !busy && !in_token;

  always_comb begin
    state_d = state_q;
    if (clr_nak) begin
      state_d = NK_RUN;
    end else begin
      case (state_q)
        NK_RUN:  if (set_nak)  state_d = NK_PEND;
        NK_PEND: if (boundary) state_d = NK_HELD;
        NK_HELD: state_d = NK_HELD;
        default: state_d = NK_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= NK_RUN;
      nak_eff_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr_nak) nak_eff_q <= 1'b0;
      else if (state_q == NK_PEND && state_d == NK_HELD) nak_eff_q <= 1'b1;
    end
  end

  assign nak_mode = (state_q == NK_HELD);
  assign nak_eff  = nak_eff_q;

  assert_clr_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_nak |=> (!nak_mode && !nak_eff));

  assert_boundary_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$rose(nak_eff));

  assert_eff_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_eff && !clr_nak) |=> nak_eff);

endmodule

// File: rtl/in_ep_resp.sv
module in_ep_resp #(
  parameter int LEN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_iso,
  input  logic              in_token,
  input  logic              host_ack,
  input  logic              host_timeout,
  input  logic              nak_mode,
  input  logic              q_empty,
  input  logic [LEN_W-1:0]  head_len,
  output in_ep_pkg::resp_e  resp,
  output logic [LEN_W-1:0]  tx_len,
  output logic              busy,
  output logic              pop
);
  import in_ep_pkg::*;

  resp_e            resp_q, resp_d;
  logic [LEN_W-1:0] tx_len_q;
  logic             busy_q;
  logic             tok_ok;
  logic             start_data;

  function automatic resp_e idle_answer(input logic iso);
    return iso ? RESP_ZLP : RESP_NAK;
  endfunction

  assign tok_ok = in_token && !busy_q;

  always_comb begin
    resp_d     = RESP_NONE;
    start_data = 1'b0;
    if (tok_ok) begin
      if (nak_mode || q_empty) begin
        resp_d = idle_answer(ep_iso);
      end else begin
        resp_d     = RESP_DATA;
        start_data = 1'b1;
      end
    end
  end

  assign pop = (start_data && ep_iso) || (busy_q && host_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q   <= RESP_NONE;
      tx_len_q <= '0;
      busy_q   <= 1'b0;
    end else begin
      resp_q   <= resp_d;
      tx_len_q <= start_data ? head_len : '0;
      if (busy_q && (host_ack || host_timeout)) busy_q <= 1'b0;
      else if (start_data && !ep_iso)          busy_q <= 1'b1;
    end
  end

  assign resp   = resp_q;
  assign tx_len = tx_len_q;
  assign busy   = busy_q;

  assert_nak_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && !busy_q && nak_mode && !ep_iso) |=> resp_q == RESP_NAK);

  assert_iso_zlp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && !busy_q && nak_mode && ep_iso) |=> resp_q == RESP_ZLP);

  assert_data_needs_queue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && q_empty) |=> resp_q != RESP_DATA);

endmodule

// File: rtl/in_ep_nak_ctrl.sv
module in_ep_nak_ctrl #(
  parameter int FIFO_BYTES = 64,
  parameter int PKT_SLOTS  = 4,
  parameter int MAX_PKT    = 64,
  localparam int LEN_W     = $clog2(MAX_PKT + 1),
  localparam int FREE_W    = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_iso,
  input  logic              set_nak,
  input  logic              clr_nak,
  input  logic              nak_irq_mask,
  input  logic              in_token,
  input  logic              host_ack,
  input  logic              host_timeout,
  input  logic              pkt_commit,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic              room_ok,
  output logic [1:0]        resp,
  output logic [LEN_W-1:0]  tx_len,
  output logic              nak_mode,
  output logic              nak_eff,
  output logic              nak_irq,
  output logic              txfe_irq,
  output logic [FREE_W-1:0] free_bytes
);
  import in_ep_pkg::*;

  logic             len_ok;
  logic             q_room;
  logic             q_empty;
  logic             q_pop;
  logic [LEN_W-1:0] q_head_len;
  logic             tx_busy;
  resp_e            resp_w;

  assign len_ok = (32'(pkt_len) <= MAX_PKT);

  in_ep_pktq #(
    .FIFO_BYTES(FIFO_BYTES), .SLOTS(PKT_SLOTS), .LEN_W(LEN_W), .FREE_W(FREE_W)
  ) u_pktq (
    .clk(clk), .rst_n(rst_n),
    .commit(pkt_commit && len_ok), .commit_len(pkt_len),
    .pop(q_pop), .head_len(q_head_len), .empty(q_empty),
    .room_ok(q_room), .free_bytes(free_bytes)
  );

  in_ep_nak_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .set_nak(set_nak), .clr_nak(clr_nak),
    .busy(tx_busy), .in_token(in_token), .nak_mode(nak_mode), .nak_eff(nak_eff)
  );

  in_ep_resp #(.LEN_W(LEN_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .ep_iso(ep_iso), .in_token(in_token),
    .host_ack(host_ack), .host_timeout(host_timeout), .nak_mode(nak_mode),
    .q_empty(q_empty), .head_len(q_head_len), .resp(resp_w), .tx_len(tx_len),
    .busy(tx_busy), .pop(q_pop)
  );

  assign room_ok  = q_room && len_ok;
  assign resp     = resp_w;
  assign nak_irq  = nak_eff && !nak_irq_mask;
  assign txfe_irq = q_empty;

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    nak_irq_mask |-> !nak_irq);

  assert_irq_means_nak_R12: assert property (@(posedge clk) disable iff (!rst_n)
    nak_irq |-> nak_mode);

  assert_no_pop_in_nak_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_mode && !tx_busy) |-> !q_pop);

endmodule

// File: tb/sim_in_ep_nak_ctrl.sv
module sim_in_ep_nak_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ep_iso = 1'b0, set_nak = 1'b0, clr_nak = 1'b0, nak_irq_mask = 1'b0;
  logic       in_token = 1'b0, host_ack = 1'b0, host_timeout = 1'b0, pkt_commit = 1'b0;
  logic [6:0] pkt_len = '0;
  logic       room_ok, nak_mode, nak_eff, nak_irq, txfe_irq;
  logic [1:0] resp;
  logic [6:0] tx_len, free_bytes;

  int tests = 0;
  int fails = 0;

  localparam int R_NONE = 0, R_DATA = 1, R_NAK = 2, R_ZLP = 3;

  always #10 clk = ~clk;

  in_ep_nak_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ep_iso(ep_iso), .set_nak(set_nak), .clr_nak(clr_nak),
    .nak_irq_mask(nak_irq_mask), .in_token(in_token), .host_ack(host_ack),
    .host_timeout(host_timeout), .pkt_commit(pkt_commit), .pkt_len(pkt_len),
    .room_ok(room_ok), .resp(resp), .tx_len(tx_len), .nak_mode(nak_mode),
    .nak_eff(nak_eff), .nak_irq(nak_irq), .txfe_irq(txfe_irq), .free_bytes(free_bytes)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic commit(input int len);
    pkt_len = 7'(len); pkt_commit = 1'b1; cyc(); pkt_commit = 1'b0;
  endtask
  task automatic token(); in_token = 1'b1; cyc(); in_token = 1'b0; endtask
  task automatic ack();   host_ack = 1'b1; cyc(); host_ack = 1'b0; endtask
  task automatic tout();  host_timeout = 1'b1; cyc(); host_timeout = 1'b0; endtask
  task automatic snak();  set_nak = 1'b1; cyc(); set_nak = 1'b0; endtask
  task automatic cnak();  clr_nak = 1'b1; cyc(); clr_nak = 1'b0; endtask

  task automatic t_reset();
    chk("R1 resp", resp, R_NONE);
    chk("R1 free", free_bytes, 64);
    chk("R1 txfe", txfe_irq, 1);
    chk("R1 nak_eff", nak_eff, 0);
    chk("R1 nak_mode", nak_mode, 0);
    chk("R1 nak_irq", nak_irq, 0);
  endtask

  task automatic t_space();
    commit(40);
    chk("R2 free after 40", free_bytes, 24);
    chk("R13 txfe low", txfe_irq, 0);
    pkt_len = 7'd30; #1;
    chk("R2 room_ok 30>24", room_ok, 0);
    commit(30);
    chk("R2 refused keeps free", free_bytes, 24);
    commit(0);
    chk("R3 zero len no bytes", free_bytes, 24);
    commit(24);
    chk("R2 exact fit", free_bytes, 0);
    pkt_len = 7'd0; #1;
    chk("R3 zero len room at free 0", room_ok, 1);
    token();
    chk("R4 data resp", resp, R_DATA);
    chk("R4 len 40", tx_len, 40);
    ack();
    chk("R5 ack frees", free_bytes, 40);
    token();
    chk("R3 zero len sent", resp, R_DATA);
    chk("R3 zero len tx_len", tx_len, 0);
    ack();
    token();
    chk("R4 len 24", tx_len, 24);
    ack();
    chk("R13 all free", free_bytes, 64);
    chk("R13 txfe high", txfe_irq, 1);
    token();
    chk("R4 empty nak", resp, R_NAK);
  endtask

  task automatic t_timeout();
    commit(10);
    token();
    chk("R5 data", tx_len, 10);
    tout();
    chk("R5 kept on timeout", free_bytes, 54);
    token();
    chk("R5 resent", resp, R_DATA);
    chk("R5 resent len", tx_len, 10);
    ack();
    chk("R5 freed on ack", free_bytes, 64);
  endtask

  task automatic t_iso();
    ep_iso = 1'b1;
    token();
    chk("R4 iso empty zlp", resp, R_ZLP);
    commit(8);
    token();
    chk("R6 iso data", resp, R_DATA);
    chk("R6 iso len", tx_len, 8);
    chk("R6 iso freed at send", free_bytes, 64);
    ep_iso = 1'b0;
  endtask

  task automatic t_nak_basic();
    commit(16);
    snak();
    chk("R9 not yet effective", nak_eff, 0);
    cyc();
    chk("R9 eff after two edges", nak_eff, 1);
    chk("R9 mode", nak_mode, 1);
    chk("R12 irq", nak_irq, 1);
    token();
    chk("R7 nak with data", resp, R_NAK);
    chk("R7 queue kept", free_bytes, 48);
    cnak();
    chk("R10 eff cleared", nak_eff, 0);
    chk("R10 mode cleared", nak_mode, 0);
    chk("R12 irq low", nak_irq, 0);
    token();
    chk("R10 kept packet sent", resp, R_DATA);
    chk("R10 kept len", tx_len, 16);
    ack();
  endtask

  task automatic t_nak_iso();
    ep_iso = 1'b1;
    commit(12);
    snak(); cyc();
    token();
    chk("R8 iso zlp in nak", resp, R_ZLP);
    chk("R8 queue kept", free_bytes, 52);
    cnak();
    token();
    chk("R10 iso data after clear", tx_len, 12);
    chk("R6 iso freed", free_bytes, 64);
    ep_iso = 1'b0;
  endtask

  task automatic t_inflight();
    commit(20);
    token();
    snak(); cyc(); cyc();
    chk("R9 waits for handshake", nak_eff, 0);
    ack();
    chk("R9 ack frees in pend", free_bytes, 64);
    chk("R9 not on ack edge", nak_eff, 0);
    cyc();
    chk("R9 eff after ack", nak_eff, 1);
    cnak();
    commit(6);
    snak();
    token();
    chk("R9 started in pend sends", resp, R_DATA);
    chk("R9 started len", tx_len, 6);
    ack(); cyc();
    chk("R9 eff after second", nak_eff, 1);
    cnak();
  endtask

  task automatic t_both();
    snak(); cyc();
    set_nak = 1'b1; clr_nak = 1'b1; cyc(); set_nak = 1'b0; clr_nak = 1'b0;
    chk("R11 clear wins held", nak_mode, 0);
    chk("R11 eff cleared", nak_eff, 0);
    set_nak = 1'b1; clr_nak = 1'b1; cyc(); set_nak = 1'b0; clr_nak = 1'b0;
    cyc(); cyc();
    chk("R11 clear wins run", nak_eff, 0);
    chk("R11 mode run", nak_mode, 0);
  endtask

  task automatic t_mask();
    nak_irq_mask = 1'b1;
    snak(); cyc();
    chk("R12 status sets masked", nak_eff, 1);
    chk("R12 line low masked", nak_irq, 0);
    nak_irq_mask = 1'b0; #1;
    chk("R12 line on unmask", nak_irq, 1);
    cnak();
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_space();
    t_timeout();
    t_iso();
    t_nak_basic();
    t_nak_iso();
    t_inflight();
    t_both();
    t_mask();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule